// File: doc/BRIEF.md
# Arithmetic Status Flag Unit

This block performs an addition or subtraction on two operands, either 8 or 16 bits wide, and derives the arithmetic status bits from that operation. The status bits are carry/borrow, low-byte parity, nibble carry for decimal adjust, zero, sign and signed overflow. The result is combinational. The status bits go into a register that loads only when a write enable is high. Three control bits sit beside the status bits: single-step trap, interrupt enable and string direction. Each control bit has its own set and clear command, and the arithmetic never changes them.

An execution stage drives the operands, the operation code, the size select and an incoming carry. The result is read in the same cycle. The stage raises `flag_we` when the instruction is meant to commit its flags, and the registered flags then appear after that clock edge. The reset input is asserted asynchronously and is released through a two-stage synchronizer.

Top module: `alu_flag_unit`

## Requirements
- R1: `result` is the sum or difference selected by `op_sel` (00 add, 01 add plus `carry_in`, 10 subtract, 11 subtract minus `carry_in`). When `word_sel`=1 the result is the full 16-bit value. When `word_sel`=0 only the low 8 bits of the operands are used and `result[15:8]` is zero.
- R2: After a write, `cf` holds the carry out of the sized MSB for additions and the borrow for subtractions.
- R3: After a write, `af` holds the carry out of bit 3 for additions and the borrow into bit 3 for subtractions.
- R4: After a write, `pf` is 1 when `result[7:0]` has an even number of ones. The upper byte is ignored even in word mode.
- R5: After a write, `zf` is 1 exactly when the sized result is zero.
- R6: After a write, `sf` equals the sized result MSB (bit 15 in word mode, bit 7 in byte mode).
- R7: After a write, `of` is 1 when the carry into the sized MSB differs from the carry out of it.
- R8: The six status bits load only on a rising clock edge with `flag_we`=1. Otherwise they hold their value.
- R9: `tf`, `ie` and `df` each go to 1 on their set command and to 0 on their clear command, with clear winning when both are high. With no command they hold, and no arithmetic write changes them.
- R10: While `rst_n` is low, all nine flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_a | input | 16 | First operand (minuend) |
| op_b | input | 16 | Second operand (subtrahend) |
| op_sel | input | 2 | Operation code |
| word_sel | input | 1 | 1 = 16-bit, 0 = 8-bit |
| carry_in | input | 1 | Carry/borrow for the with-carry operations |
| flag_we | input | 1 | Status flag write enable |
| trap_set | input | 1 | Set trap bit |
| trap_clr | input | 1 | Clear trap bit |
| intr_set | input | 1 | Set interrupt-enable bit |
| intr_clr | input | 1 | Clear interrupt-enable bit |
| dir_set | input | 1 | Set direction bit |
| dir_clr | input | 1 | Clear direction bit |
| result | output | 16 | Arithmetic result |
| cf | output | 1 | Carry/borrow flag |
| pf | output | 1 | Parity flag |
| af | output | 1 | Nibble carry flag |
| zf | output | 1 | Zero flag |
| sf | output | 1 | Sign flag |
| of | output | 1 | Overflow flag |
| tf | output | 1 | Trap control bit |
| ie | output | 1 | Interrupt-enable control bit |
| df | output | 1 | Direction control bit |

## Verification
The bench drives the sign-boundary crossings 0x7F+1 and 0x7FFF+1. A design that takes the MSB from the wrong width would miss overflow and sign on one of them. It drives wrap-to-zero sums and subtractions that borrow, so an unconverted adder carry would show up as an inverted `cf` or `af`. Byte-mode cases put garbage in the upper operand bytes, and word-mode cases have an odd-parity upper byte, which exposes designs that leak the high byte into zero or parity. Writes with the enable low, control commands given both alone and together, and a reset after the flags are set cover the hold, priority and clearing behaviour.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam int unsigned NIB_W = 4;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_ADC = 2'b01,
    OP_SUB = 2'b10,
    OP_SBB = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } stat_flags_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import alu_flag_pkg::*;
#(
  parameter int unsigned W    = 16,
  parameter int unsigned HALF = W / 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   op_sel,
  input  logic         word_sel,
  input  logic         carry_in,
  output logic [W-1:0] result,
  output logic         c_out,
  output logic         c_msb_in,
  output logic         c_nib,
  output logic         is_sub
);
  alu_op_e     op_e;
  logic        use_c;
  logic        cin;
  logic [W-1:0] b_eff;
  logic [W:0]   sum_w;
  logic [HALF:0] sum_h;

  always_comb begin
    op_e   = alu_op_e'(op_sel);
    is_sub = (op_e == OP_SUB) || (op_e == OP_SBB);
    use_c  = (op_e == OP_ADC) || (op_e == OP_SBB);
    // subtract is a + ~b + 1, with the borrow folded into the carry-in
    cin    = is_sub ? ~(use_c & carry_in) : (use_c & carry_in);
    b_eff  = is_sub ? ~b : b;
    sum_w  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    sum_h  = {1'b0, a[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]} + {{HALF{1'b0}}, cin};
    c_nib  = a[NIB_W] ^ b_eff[NIB_W] ^ sum_w[NIB_W];
    if (word_sel) begin
      result   = sum_w[W-1:0];
      c_out    = sum_w[W];
      c_msb_in = a[W-1] ^ b_eff[W-1] ^ sum_w[W-1];
    end else begin
      result   = {{(W-HALF){1'b0}}, sum_h[HALF-1:0]};
      c_out    = sum_h[HALF];
      c_msb_in = a[HALF-1] ^ b_eff[HALF-1] ^ sum_h[HALF-1];
    end
  end
endmodule

// File: rtl/alu_status_calc.sv
module alu_status_calc
  import alu_flag_pkg::*;
#(
  parameter int unsigned W    = 16,
  parameter int unsigned HALF = W / 2
) (
  input  logic [W-1:0] result,
  input  logic         word_sel,
  input  logic         c_out,
  input  logic         c_msb_in,
  input  logic         c_nib,
  input  logic         is_sub,
  output stat_flags_t  flags
);
  logic [HALF-1:0] par_chain;

  assign par_chain[0] = result[0];
  for (genvar i = 1; i < HALF; i++) begin : g_par
    assign par_chain[i] = par_chain[i-1] ^ result[i];
  end

  always_comb begin
    flags.cf = c_out ^ is_sub;
    flags.af = c_nib ^ is_sub;
    flags.of = c_msb_in ^ c_out;
    flags.pf = ~par_chain[HALF-1];
    flags.zf = word_sel ? (result == '0) : (result[HALF-1:0] == '0);
    flags.sf = word_sel ? result[W-1] : result[HALF-1];
  end
endmodule

// File: rtl/alu_ctrl_flags.sv
module alu_ctrl_flags #(
  parameter int unsigned N_CTL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CTL-1:0] ctl_set,
  input  logic [N_CTL-1:0] ctl_clr,
  output logic [N_CTL-1:0] ctl_q
);
  logic [N_CTL-1:0] ctl_d;

  for (genvar i = 0; i < N_CTL; i++) begin : g_ctl
    always_comb begin
      if (ctl_clr[i])      ctl_d[i] = 1'b0;
      else if (ctl_set[i]) ctl_d[i] = 1'b1;
      else                 ctl_d[i] = ctl_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q[i] <= 1'b0;
      else        ctl_q[i] <= ctl_d[i];
    end

    // R9: clear has priority, set loads, idle holds
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_clr[i] |=> !ctl_q[i]);
    a_r9_set_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_set[i] && !ctl_clr[i]) |=> ctl_q[i]);
    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_set[i] && !ctl_clr[i]) |=> $stable(ctl_q[i]));
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int unsigned W    = 16,
  localparam int unsigned HALF = W / 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [1:0]   op_sel,
  input  logic         word_sel,
  input  logic         carry_in,
  input  logic         flag_we,
  input  logic         trap_set,
  input  logic         trap_clr,
  input  logic         intr_set,
  input  logic         intr_clr,
  input  logic         dir_set,
  input  logic         dir_clr,
  output logic [W-1:0] result,
  output logic         cf,
  output logic         pf,
  output logic         af,
  output logic         zf,
  output logic         sf,
  output logic         of,
  output logic         tf,
  output logic         ie,
  output logic         df
);
  logic [1:0]  rst_pipe;
  logic        rst_q_n;
  logic        c_out, c_msb_in, c_nib, is_sub;
  stat_flags_t stat_new, stat_d, stat_q;
  logic [2:0]  ctl_q;

  // reset: asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  alu_addsub #(.W(W), .HALF(HALF)) i_addsub (
    .a        (op_a),
    .b        (op_b),
    .op_sel   (op_sel),
    .word_sel (word_sel),
    .carry_in (carry_in),
    .result   (result),
    .c_out    (c_out),
    .c_msb_in (c_msb_in),
    .c_nib    (c_nib),
    .is_sub   (is_sub)
  );

  alu_status_calc #(.W(W), .HALF(HALF)) i_status (
    .result   (result),
    .word_sel (word_sel),
    .c_out    (c_out),
    .c_msb_in (c_msb_in),
    .c_nib    (c_nib),
    .is_sub   (is_sub),
    .flags    (stat_new)
  );

  alu_ctrl_flags #(.N_CTL(3)) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .ctl_set ({dir_set, intr_set, trap_set}),
    .ctl_clr ({dir_clr, intr_clr, trap_clr}),
    .ctl_q   (ctl_q)
  );

  always_comb begin
    stat_d = flag_we ? stat_new : stat_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) stat_q <= '0;
    else          stat_q <= stat_d;
  end

  assign cf = stat_q.cf;
  assign pf = stat_q.pf;
  assign af = stat_q.af;
  assign zf = stat_q.zf;
  assign sf = stat_q.sf;
  assign of = stat_q.of;
  assign tf = ctl_q[0];
  assign ie = ctl_q[1];
  assign df = ctl_q[2];

  logic add_ovf_word;
  assign add_ovf_word = flag_we && !op_sel[1] && word_sel &&
                        (op_a[W-1] == op_b[W-1]) && (result[W-1] != op_a[W-1]);

  // R8: no write enable, no change to status
  a_r8_hold_without_we: assert property (@(posedge clk) disable iff (!rst_q_n)
    !flag_we |=> $stable(stat_q));
  // R7: like-signed word add that flips the sign reports overflow
  a_r7_word_add_overflow: assert property (@(posedge clk) disable iff (!rst_q_n)
    add_ovf_word |=> of);
  // R4 / R5: a zero low byte always has even parity
  a_r4_zero_even_parity: assert property (@(posedge clk) disable iff (!rst_q_n)
    zf |-> pf);
  // R6 / R5: a zero result cannot be negative
  a_r6_zero_not_negative: assert property (@(posedge clk) disable iff (!rst_q_n)
    zf |-> !sf);
  // R10: everything cleared while reset is held
  a_r10_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (stat_q == '0) && (ctl_q == '0));
endmodule

// File: tb/test_alu_flag_unit.sv
module test_alu_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] op_a, op_b, result;
  logic [1:0]  op_sel;
  logic        word_sel, carry_in, flag_we;
  logic        trap_set, trap_clr, intr_set, intr_clr, dir_set, dir_clr;
  logic        cf, pf, af, zf, sf, of, tf, ie, df;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic [15:0] res;
    logic [8:0]  fl; // {df,ie,tf,of,sf,zf,af,pf,cf}
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  logic [5:0] m_stat = '0; // {of,sf,zf,af,pf,cf}
  logic [2:0] m_ctl  = '0; // {df,ie,tf}

  always #2 clk = ~clk;

  alu_flag_unit i_alu_flag_unit (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .word_sel(word_sel), .carry_in(carry_in), .flag_we(flag_we),
    .trap_set(trap_set), .trap_clr(trap_clr), .intr_set(intr_set),
    .intr_clr(intr_clr), .dir_set(dir_set), .dir_clr(dir_clr),
    .result(result), .cf(cf), .pf(pf), .af(af), .zf(zf), .sf(sf), .of(of),
    .tf(tf), .ie(ie), .df(df)
  );

  task automatic compare(input exp_t e);
    logic [8:0] act;
    string names[9];
    string reqs[9];
    bit bad;
    names = '{"cf","pf","af","zf","sf","of","tf","ie","df"};
    reqs  = '{"R2","R4","R3","R5","R6","R7","R9","R9","R9"};
    act = {df, ie, tf, of, sf, zf, af, pf, cf};
    bad = 1'b0;
    n_cmp++;
    if (result !== e.res) begin
      $display("FAIL R1 [%s] result act=%h exp=%h", e.tag, result, e.res);
      bad = 1'b1;
    end
    for (int k = 0; k < 9; k++) begin
      if (act[k] !== e.fl[k]) begin
        $display("FAIL %s [%s] %s act=%b exp=%b", reqs[k], e.tag, names[k], act[k], e.fl[k]);
        bad = 1'b1;
      end
    end
    if (bad) n_bad++;
  endtask

  // scoreboard monitor: one expected item per clock edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) compare(sb_q.pop_front());
    end
  end

  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic [1:0] op,
                       input logic w, input logic ci, input logic we,
                       input logic [2:0] set3, input logic [2:0] clr3, input string tag);
    int n, mask, ai, bi, c, full, rs;
    logic [15:0] res;
    logic ecf, eaf, eof, esa, esb, esr;
    exp_t e;
    @(negedge clk);
    op_a = a; op_b = b; op_sel = op; word_sel = w; carry_in = ci; flag_we = we;
    {dir_set, intr_set, trap_set} = set3;
    {dir_clr, intr_clr, trap_clr} = clr3;
    n = w ? 16 : 8;
    mask = (1 << n) - 1;
    ai = int'(a) & mask;
    bi = int'(b) & mask;
    c = (op[0] && ci) ? 1 : 0;
    if (!op[1]) begin
      full = ai + bi + c;
      ecf = (full > mask);
      eaf = (((ai & 15) + (bi & 15) + c) > 15);
    end else begin
      full = ai - bi - c;
      ecf = (ai < bi + c);
      eaf = ((ai & 15) < ((bi & 15) + c));
    end
    rs = full & mask;
    res = rs[15:0];
    esa = a[n-1]; esb = b[n-1]; esr = res[n-1];
    eof = !op[1] ? ((esa == esb) && (esr != esa)) : ((esa != esb) && (esr != esa));
    if (we) m_stat = {eof, esr, (res == 16'h0), eaf, ~^res[7:0], ecf};
    for (int k = 0; k < 3; k++) begin
      if (clr3[k])      m_ctl[k] = 1'b0;
      else if (set3[k]) m_ctl[k] = 1'b1;
    end
    e.res = res;
    e.fl  = {m_ctl, m_stat};
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] x;
    logic [15:0] y;
    exp_t z;
    rst_n = 1'b0;
    op_a = '0; op_b = '0; op_sel = '0; word_sel = 1'b0; carry_in = 1'b0; flag_we = 1'b0;
    {trap_set, trap_clr, intr_set, intr_clr, dir_set, dir_clr} = '0;
    repeat (3) @(negedge clk);
    z.res = 16'h0; z.fl = '0; z.tag = "R10 reset state";
    compare(z);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R6 R7 R3: byte sign boundary
    apply(16'h007F, 16'h0001, 2'b00, 1'b0, 1'b0, 1'b1, 3'b000, 3'b000, "R7 byte 7F+1");
    // R2 R5 R4: byte wrap to zero
    apply(16'h00FF, 16'h0001, 2'b00, 1'b0, 1'b0, 1'b1, 3'b000, 3'b000, "R2 byte FF+1");
    // R1: upper operand bytes ignored in byte mode
    apply(16'hAB81, 16'hCD81, 2'b00, 1'b0, 1'b0, 1'b1, 3'b000, 3'b000, "R1 byte high ignored");
    // R7: word sign boundary
    apply(16'h7FFF, 16'h0001, 2'b00, 1'b1, 1'b0, 1'b1, 3'b000, 3'b000, "R7 word 7FFF+1");
    apply(16'hFFFF, 16'h0001, 2'b00, 1'b1, 1'b0, 1'b1, 3'b000, 3'b000, "R5 word wrap");
    // R2 R3: borrow on subtract
    apply(16'h0000, 16'h0001, 2'b10, 1'b0, 1'b0, 1'b1, 3'b000, 3'b000, "R2 byte 0-1 borrow");
    apply(16'h8000, 16'h0001, 2'b10, 1'b1, 1'b0, 1'b1, 3'b000, 3'b000, "R7 word 8000-1");
    apply(16'h1234, 16'h1234, 2'b10, 1'b1, 1'b0, 1'b1, 3'b000, 3'b000, "R5 word equal sub");
    // R1: with-carry forms, and carry ignored by plain forms
    apply(16'h000F, 16'h0000, 2'b01, 1'b0, 1'b1, 1'b1, 3'b000, 3'b000, "R3 adc nibble carry");
    apply(16'h000F, 16'h0000, 2'b00, 1'b0, 1'b1, 1'b1, 3'b000, 3'b000, "R1 add ignores carry_in");
    apply(16'h0010, 16'h0000, 2'b11, 1'b1, 1'b1, 1'b1, 3'b000, 3'b000, "R3 sbb nibble borrow");
    apply(16'h0000, 16'h0000, 2'b11, 1'b1, 1'b1, 1'b1, 3'b000, 3'b000, "R2 sbb 0-0-1");
    // R4: parity from low byte only
    apply(16'h0103, 16'h0000, 2'b00, 1'b1, 1'b0, 1'b1, 3'b000, 3'b000, "R4 word parity low byte");
    apply(16'h0300, 16'h0001, 2'b00, 1'b1, 1'b0, 1'b1, 3'b000, 3'b000, "R4 word odd low byte");
    // R8: no write, flags hold while result still moves
    apply(16'h00FF, 16'h0001, 2'b00, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, "R8 hold no we");
    apply(16'h8000, 16'h8000, 2'b00, 1'b1, 1'b0, 1'b0, 3'b000, 3'b000, "R8 hold no we 2");
    // R9: control bits
    apply(16'h0000, 16'h0000, 2'b00, 1'b0, 1'b0, 1'b0, 3'b111, 3'b000, "R9 set all");
    apply(16'h7FFF, 16'h0001, 2'b00, 1'b1, 1'b0, 1'b1, 3'b000, 3'b000, "R9 arith leaves ctl");
    apply(16'h0000, 16'h0000, 2'b10, 1'b1, 1'b0, 1'b1, 3'b000, 3'b000, "R9 arith zero leaves ctl");
    apply(16'h0000, 16'h0000, 2'b00, 1'b0, 1'b0, 1'b0, 3'b010, 3'b011, "R9 clear wins");
    apply(16'h0000, 16'h0000, 2'b00, 1'b0, 1'b0, 1'b0, 3'b001, 3'b100, "R9 set tf clr df");
    // mixed sweep
    x = 16'hACE1; y = 16'h1D35;
    for (int i = 0; i < 48; i++) begin
      x = {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
      y = y * 16'd5 + 16'h3217;
      apply(x, y, i[1:0], i[2], i[3], 1'b1, 3'b000, 3'b000, "R1 sweep");
    end
    repeat (3) @(negedge clk);
    // R10: reset after activity clears everything
    apply(16'hFFFF, 16'h0001, 2'b00, 1'b1, 1'b0, 1'b1, 3'b111, 3'b000, "R10 pre-reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    op_a = '0; op_b = '0; flag_we = 1'b0; trap_set = 1'b0; intr_set = 1'b0; dir_set = 1'b0;
    #1;
    z.res = 16'h0; z.fl = '0; z.tag = "R10 reset after use";
    compare(z);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule